// File: doc/BRIEF.md
# Three-Phase PWM Shutdown Controller

This block guards six three-phase PWM pins: three phase drives and their complements. The PWM levels come in from an upstream generator. The block passes them through to the pins when output is enabled. It also produces a drive-enable per pin, so that the pad can float the pin when output is off. An active-low shutdown input acts as an emergency stop. It is brought into the clock domain through a two-flop synchronizer. If the protection is armed and output is enabled when that input goes low, the block clears output enable, floats all six pins and latches a trip flag.

Software controls the block through a single 3-bit write port, and every write loads the enable and arm fields together. After a trip, software must do two things to resume:

- Re-enable output once the shutdown input has gone high again.
- Re-arm protection by writing the arm bit 0 and then 1. Writing 1 on its own does not re-arm.

The `armed_o` output reports whether protection is actually in force. `arm_o` returns the value last written.

Top module: `pwm_shutdown`

## Requirements
- R1: During and after reset, and before any write, `oe_o`, `arm_o`, `armed_o` and `trip_o` are 0, every `pwm_en_o` bit is 0 and `pwm_o` is 0.
- R2: While `oe_o` is 1, every `pwm_en_o` bit is 1 and `pwm_o` equals `pwm_i` in the same cycle. While `oe_o` is 0, `pwm_en_o` and `pwm_o` are all 0.
- R3: If `sd_ni` is low at rising edges k and k+1, and at edge k+1 `armed_o` and `oe_o` are 1, then `oe_o` is 0 and `trip_o` is 1 after edge k+2. Both are still unchanged after edge k+1.
- R4: While `armed_o` is 0, a low `sd_ni` never clears `oe_o` and never sets `trip_o`.
- R5: A write (`ctl_we_i`=1) loads `oe_o` from `ctl_wdata_i[0]`. If the synchronized shutdown is low at that edge, `oe_o` becomes 0 even when bit 0 is 1.
- R6: Each write loads `arm_o` from `ctl_wdata_i[1]`. Before any trip, writing bit 1 as 1 sets `armed_o`, and writing it as 0 clears `armed_o`.
- R7: A cutoff clears `armed_o`. After a cutoff, writes with bit 1 set leave `armed_o` at 0 until a write with bit 1 clear has landed on a later edge than the cutoff. The next write with bit 1 set then sets `armed_o`.
- R8: A cutoff sets `trip_o`, and `trip_o` holds until a write with `ctl_wdata_i[2]`=1. If that write lands on the same edge as a cutoff, `trip_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_ni | input | 1 | Asynchronous shutdown request, active low |
| pwm_i | input | 6 | PWM levels from the generator |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 3 | Write data: bit0 output enable, bit1 arm, bit2 trip clear (write 1) |
| oe_o | output | 1 | Output-enable readback |
| arm_o | output | 1 | Arm bit readback (last value written) |
| armed_o | output | 1 | Protection in force |
| trip_o | output | 1 | Sticky cutoff flag |
| pwm_o | output | 6 | Pin levels, 0 while disabled |
| pwm_en_o | output | 6 | Per-pin drive enable; 0 means high impedance |

## Verification
A cutoff and a software write can fall on the same clock edge. This matters most when the write clears the trip flag, re-enables output or writes the arm bit as 0. The bench holds shutdown low, with protection armed and output enabled, for exactly the two synchronizer edges. It then issues such writes on the third edge. The outcome must be the following: the trip flag stays set, output stays off, and the 0 arm write does not count toward re-arming. Random runs with long shutdown pulses produce further collisions, and a cycle model judges them.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;
  localparam int unsigned NUM_PINS = 6;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CTL_W = 3;
  localparam int unsigned CTL_OE = 0;
  localparam int unsigned CTL_ARM = 1;
  localparam int unsigned CTL_CLR = 2;
endpackage

// File: rtl/pwm_sd_sync.sv
module pwm_sd_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwm_sd_ctrl.sv
module pwm_sd_ctrl
  import pwm_sd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sd_low_i,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             oe_o,
  output logic             arm_o,
  output logic             armed_o,
  output logic             lock_o,
  output logic             trip_o
);
  logic oe_q, arm_q, gate_q, lock_q, trip_q, cut;

  assign cut = gate_q & oe_q & sd_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
      lock_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      if (cut)       oe_q <= 1'b0;
      else if (we_i) oe_q <= wdata_i[CTL_OE] & ~sd_low_i;

      if (we_i) arm_q <= wdata_i[CTL_ARM];

      // effective arming: a 1 write only counts once the lock is cleared by a 0 write
      if (cut)       gate_q <= 1'b0;
      else if (we_i) gate_q <= wdata_i[CTL_ARM] & ~lock_q;

      if (cut)                            lock_q <= 1'b1;
      else if (we_i && !wdata_i[CTL_ARM]) lock_q <= 1'b0;

      if (cut)                           trip_q <= 1'b1;
      else if (we_i && wdata_i[CTL_CLR]) trip_q <= 1'b0;
    end
  end

  assign oe_o    = oe_q;
  assign arm_o   = arm_q;
  assign armed_o = gate_q;
  assign lock_o  = lock_q;
  assign trip_o  = trip_q;
endmodule

// File: rtl/pwm_sd_gate.sv
module pwm_sd_gate #(
  parameter int unsigned PINS = 6
) (
  input  logic            oe_i,
  input  logic [PINS-1:0] pwm_i,
  output logic [PINS-1:0] pwm_o,
  output logic [PINS-1:0] en_o
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    assign en_o[g]  = oe_i;
    assign pwm_o[g] = oe_i & pwm_i[g];
  end
endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown
  import pwm_sd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sd_ni,
  input  logic [NUM_PINS-1:0] pwm_i,
  input  logic                ctl_we_i,
  input  logic [CTL_W-1:0]    ctl_wdata_i,
  output logic                oe_o,
  output logic                arm_o,
  output logic                armed_o,
  output logic                trip_o,
  output logic [NUM_PINS-1:0] pwm_o,
  output logic [NUM_PINS-1:0] pwm_en_o
);
  logic sd_sync, sd_low, lock_w;

  pwm_sd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sd_ni),
    .q_o   (sd_sync)
  );

  assign sd_low = ~sd_sync;

  pwm_sd_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sd_low_i(sd_low),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .oe_o    (oe_o),
    .arm_o   (arm_o),
    .armed_o (armed_o),
    .lock_o  (lock_w),
    .trip_o  (trip_o)
  );

  pwm_sd_gate #(.PINS(NUM_PINS)) u_gate (
    .oe_i (oe_o),
    .pwm_i(pwm_i),
    .pwm_o(pwm_o),
    .en_o (pwm_en_o)
  );
endmodule

// File: rtl/pwm_shutdown_chk.sv
module pwm_shutdown_chk
  import pwm_sd_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sd_low,
  input logic                lock,
  input logic                ctl_we_i,
  input logic [CTL_W-1:0]    ctl_wdata_i,
  input logic                oe_o,
  input logic                armed_o,
  input logic                trip_o,
  input logic [NUM_PINS-1:0] pwm_en_o
);
  AST_OFF_IS_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (pwm_en_o == '0));  // R2

  AST_CUTOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && oe_o && sd_low) |=> (!oe_o && trip_o));  // R3

  AST_DISARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && oe_o && !ctl_we_i) |=> oe_o);  // R4

  AST_OE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && sd_low) |=> !oe_o);  // R5

  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && ctl_we_i && ctl_wdata_i[CTL_ARM]) |=> !armed_o);  // R7

  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !(ctl_we_i && ctl_wdata_i[CTL_CLR])) |=> trip_o);  // R8
endmodule

bind pwm_shutdown pwm_shutdown_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sd_low     (sd_low),
  .lock       (lock_w),
  .ctl_we_i   (ctl_we_i),
  .ctl_wdata_i(ctl_wdata_i),
  .oe_o       (oe_o),
  .armed_o    (armed_o),
  .trip_o     (trip_o),
  .pwm_en_o   (pwm_en_o)
);

// File: tb/pwm_shutdown_test.sv
`timescale 1ns/1ps
module pwm_shutdown_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sd_ni = 1'b1;
  logic [5:0] pwm_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [2:0] ctl_wdata_i = '0;
  logic       oe_o, arm_o, armed_o, trip_o;
  logic [5:0] pwm_o, pwm_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit m_s0, m_s1, m_oe, m_arm, m_gate, m_lock, m_trip;

  always #5 clk_i = ~clk_i;

  pwm_shutdown uut (.*);

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_pwm(input bit oe, input logic [5:0] lvl);
    return oe ? lvl : 6'h00;
  endfunction

  task automatic model_reset();
    m_s0 = 1; m_s1 = 1; m_oe = 0; m_arm = 0; m_gate = 0; m_lock = 0; m_trip = 0;
  endtask

  task automatic compare_all();
    chk("R5 oe", {5'd0, oe_o}, {5'd0, m_oe});
    chk("R6 arm", {5'd0, arm_o}, {5'd0, m_arm});
    chk("R7 armed", {5'd0, armed_o}, {5'd0, m_gate});
    chk("R8 trip", {5'd0, trip_o}, {5'd0, m_trip});
    chk("R2 pwm", pwm_o, exp_pwm(m_oe, pwm_i));
    chk("R2 en", pwm_en_o, m_oe ? 6'h3f : 6'h00);
  endtask

  // one clock: drive at negedge, advance model at posedge, compare after
  task automatic step(input bit we, input logic [2:0] wd, input bit sd, input logic [5:0] lvl);
    bit cut;
    @(negedge clk_i);
    ctl_we_i = we; ctl_wdata_i = wd; sd_ni = sd; pwm_i = lvl;
    @(posedge clk_i);
    cut = m_gate & m_oe & ~m_s1;
    if (cut) m_oe = 0; else if (we) m_oe = wd[0] & m_s1;
    if (we) m_arm = wd[1];
    if (cut) m_lock = 1; else if (we && !wd[1]) m_lock = 0;
    if (cut) m_gate = 0; else if (we) m_gate = wd[1] & ~m_lock_prev(cut, we, wd);
    if (cut) m_trip = 1; else if (we && wd[2]) m_trip = 0;
    m_s1 = m_s0; m_s0 = sd;
    #1;
    compare_all();
  endtask

  // lock value before this edge (gate uses the pre-edge lock)
  bit lock_before;
  function automatic bit m_lock_prev(input bit cut, input bit we, input logic [2:0] wd);
    return lock_before;
  endfunction

  task automatic w(input logic [2:0] wd, input bit sd);
    lock_before = m_lock;
    step(1'b1, wd, sd, 6'($urandom));
  endtask

  task automatic idle(input bit sd);
    lock_before = m_lock;
    step(1'b0, 3'b000, sd, 6'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    // R1 during reset
    chk("R1 oe", {5'd0, oe_o}, 6'd0);
    chk("R1 flags", {3'd0, arm_o, armed_o, trip_o}, 6'd0);
    chk("R1 en", pwm_en_o, 6'd0);
    chk("R1 pwm", pwm_o, 6'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(1'b1); idle(1'b1);
    chk("R1 post", {2'd0, oe_o, arm_o, armed_o, trip_o}, 6'd0);

    // R2/R6 enable and arm
    w(3'b011, 1'b1);
    chk("R6 armed set", {5'd0, armed_o}, 6'd1);
    repeat (4) idle(1'b1);

    // R3 latency: still on after 2 edges, off after third
    lock_before = m_lock; step(0, 3'b000, 1'b0, 6'h2a);
    lock_before = m_lock; step(0, 3'b000, 1'b0, 6'h15);
    chk("R3 still on", {5'd0, oe_o}, 6'd1);
    lock_before = m_lock; step(0, 3'b000, 1'b0, 6'h3f);
    chk("R3 cut", {4'd0, oe_o, trip_o}, 6'b000001);
    chk("R3 hiz", pwm_en_o, 6'd0);

    // R5 oe=1 ignored while low
    w(3'b011, 1'b0);
    chk("R5 blocked", {5'd0, oe_o}, 6'd0);
    idle(1'b1); idle(1'b1);
    // R7 arm=1 alone does not re-arm
    w(3'b011, 1'b1);
    chk("R7 no rearm", {4'd0, oe_o, armed_o}, 6'b000010);
    w(3'b001, 1'b1);
    w(3'b011, 1'b1);
    chk("R7 rearm", {5'd0, armed_o}, 6'd1);

    // R4 disarmed: low sd has no effect
    w(3'b001, 1'b1);
    repeat (5) idle(1'b0);
    chk("R4 no cut", {4'd0, oe_o, trip_o}, 6'b000011);
    repeat (2) idle(1'b1);
    // R8 clear
    w(3'b111, 1'b1);
    chk("R8 cleared", {5'd0, trip_o}, 6'd0);

    // collision: cutoff edge meets clear/enable/arm0 write
    w(3'b011, 1'b1);
    idle(1'b0); idle(1'b0);
    w(3'b101, 1'b0);
    chk("R8 set wins", {4'd0, oe_o, trip_o}, 6'b000001);
    idle(1'b1); idle(1'b1);
    w(3'b011, 1'b1);
    chk("R7 same-edge zero ignored", {5'd0, armed_o}, 6'd0);
    w(3'b101, 1'b1);
    w(3'b011, 1'b1);
    chk("R7 rearm after zero", {5'd0, armed_o}, 6'd1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit sd;
      sd = sd_ni;
      if (($urandom % 10) == 0) sd = ~sd;
      if (($urandom % 3) == 0) begin
        logic [2:0] wd;
        wd = 3'($urandom);
        if (($urandom % 4) != 0) wd[2] = 1'b0;
        w(wd, sd);
      end else begin
        idle(sd);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule